// File: doc/BRIEF.md
# Control-Field Clock-Domain Transfer

This block carries a 3-bit control field from a fast register clock into a much slower serial bit clock. Software writes a register word in the fast domain. The low three bits form the field: a transmit disable, a receive disable and an alternate-mode select. The slow domain sees a registered copy of the field, and every bit of that copy changes on the same bit-clock edge.

Each transfer is a toggle handshake. The fast side flips a request toggle and holds the data bus steady. The request passes through a two-flop synchronizer. The slow side then commits the bus into its copy and flips an acknowledge toggle, which returns through a second two-flop synchronizer. If the register is rewritten while a transfer is in flight, the newest value goes into a holding register and is launched as soon as the acknowledge arrives. Values written between those two points are discarded, so only the latest one is sent.

The fast side runs an FSM with two states. In `F_IDLE` no transfer is outstanding; a write launches one (transition `LAUNCH`). In `F_WAIT_ACK` a write updates the holding register (`HOLD`). When the acknowledge arrives, the FSM returns to `F_IDLE` (`RETIRE`), or it stays in `F_WAIT_ACK` and sends either the held value or a write arriving in that same cycle (`RELAUNCH`). The slow side also has two states. In `S_IDLE` it waits for the request toggle to differ from its acknowledge (`DETECT`). In `S_COMMIT` it loads the field, flips the acknowledge and returns (`APPLY`).

Top module: `ctrl_xfer_cdc`

## Requirements
- R1: After reset, rd_data, busy, pend_valid, s_tx_off, s_rx_off and s_alt are all 0.
- R2: A write stores bits [2:0] of wr_data (bit 0 transmit disable, bit 1 receive disable, bit 2 alternate mode). From the next fast-clock edge, rd_data returns those bits, with every higher bit read as 0.
- R3: A write while busy is low starts a transfer, and busy is high after that same fast-clock edge.
- R4: The slow-domain outputs {s_alt, s_rx_off, s_tx_off} change together on a single bit-clock edge. They take the launched value within five bit-clock periods of the write that launched it.
- R5: Writes made while a transfer is in flight do not change the value that transfer delivers.
- R6: A write while busy is high, and no acknowledge is arriving, sets pend_valid from the next fast-clock edge. Only the newest such value is kept.
- R7: When the transfer completes, the held value is launched and pend_valid clears while busy stays high. The slow domain then receives the held value, and no older value is ever delivered.
- R8: With nothing held, busy falls within five bit-clock periods plus six fast-clock periods of the launching write. A rewrite of the value already in the slow domain completes without changing the slow-domain outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Fast register clock |
| frst_n | input | 1 | Active-low reset, fast domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write word; bits [2:0] are the field |
| rd_data | output | REG_W | Register read-back; field in [2:0], zeros above |
| busy | output | 1 | Transfer outstanding |
| pend_valid | output | 1 | Holding register has an unsent value |
| sclk | input | 1 | Slow serial bit clock |
| srst_n | input | 1 | Active-low reset, slow domain |
| s_tx_off | output | 1 | Synchronized transmit disable |
| s_rx_off | output | 1 | Synchronized receive disable |
| s_alt | output | 1 | Synchronized alternate-mode select |

## Verification
The hardest case to reach is a write that lands on the exact fast-clock edge where the returning acknowledge is seen. In that cycle the FSM must launch the new write directly instead of the older held value. The ports show nothing that marks that edge. The stimulus therefore launches one value and then issues a second write after a delay that sweeps across every fast-clock offset through the whole transfer window, so one offset lands on the acknowledge edge. A scoreboard expects exactly the first value followed by the second, at every offset.

// File: rtl/ctrl_cdc_pkg.sv
package ctrl_cdc_pkg;
    localparam int FIELD_W = 3;

    typedef struct packed {
        logic alt_mode;
        logic rx_off;
        logic tx_off;
    } ctrl_field_t;

    typedef enum logic [0:0] {
        F_IDLE     = 1'b0,
        F_WAIT_ACK = 1'b1
    } fast_state_e;

    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_COMMIT = 1'b1
    } slow_state_e;
endpackage

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ctrl_launch.sv
module ctrl_launch
    import ctrl_cdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  ctrl_field_t wr_field,
    input  logic        ack_sync,
    output logic        req_tgl,
    output ctrl_field_t launch_data,
    output ctrl_field_t shadow,
    output logic        busy,
    output logic        pend_valid
);
    fast_state_e state, state_nx;
    ctrl_field_t pend_data;
    logic        ack_match;

    assign ack_match = (ack_sync == req_tgl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nx;
    end

    // transitions: LAUNCH, HOLD, RETIRE, RELAUNCH
    always_comb begin
        state_nx = state;
        unique case (state)
            F_IDLE:     if (wr_en) state_nx = F_WAIT_ACK;
            F_WAIT_ACK: if (ack_match && !wr_en && !pend_valid) state_nx = F_IDLE;
            default:    state_nx = F_IDLE;
        endcase
    end

    // outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl     <= 1'b0;
            launch_data <= '0;
            shadow      <= '0;
            pend_data   <= '0;
            pend_valid  <= 1'b0;
        end else begin
            if (wr_en) shadow <= wr_field;
            unique case (state)
                F_IDLE: begin
                    if (wr_en) begin
                        launch_data <= wr_field;
                        req_tgl     <= ~req_tgl;
                    end
                end
                F_WAIT_ACK: begin
                    if (ack_match) begin
                        if (wr_en) begin
                            launch_data <= wr_field;
                            req_tgl     <= ~req_tgl;
                            pend_valid  <= 1'b0;
                        end else if (pend_valid) begin
                            launch_data <= pend_data;
                            req_tgl     <= ~req_tgl;
                            pend_valid  <= 1'b0;
                        end
                    end else if (wr_en) begin
                        pend_data  <= wr_field;
                        pend_valid <= 1'b1;
                    end
                end
                default: pend_valid <= 1'b0;
            endcase
        end
    end

    assign busy = (state == F_WAIT_ACK);

    // R7
    pend_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> busy);

    // R5
    launch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (req_tgl == $past(req_tgl))) |-> $stable(launch_data));

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy) |=> busy);

    // R6
    hold_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && !ack_match) |=> pend_valid);
endmodule

// File: rtl/ctrl_capture.sv
module ctrl_capture
    import ctrl_cdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_sync,
    input  ctrl_field_t launch_data,
    output logic        ack_tgl,
    output ctrl_field_t s_field
);
    slow_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions: DETECT, APPLY
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_sync != ack_tgl) state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl <= 1'b0;
            s_field <= '0;
        end else if (state == S_COMMIT) begin
            s_field <= launch_data;
            ack_tgl <= req_sync;
        end
    end

    // R4
    single_edge_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_field) |-> $past(state == S_COMMIT));

    // R4
    ack_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_tgl) |-> $past(state == S_COMMIT));
endmodule

// File: rtl/ctrl_xfer_cdc.sv
module ctrl_xfer_cdc
    import ctrl_cdc_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             fclk,
    input  logic             frst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             busy,
    output logic             pend_valid,
    input  logic             sclk,
    input  logic             srst_n,
    output logic             s_tx_off,
    output logic             s_rx_off,
    output logic             s_alt
);
    localparam int PAD_W = REG_W - FIELD_W;

    ctrl_field_t wr_field, shadow, launch_data, s_field;
    logic        req_tgl, req_sync, ack_tgl, ack_sync;

    assign wr_field = ctrl_field_t'(wr_data[FIELD_W-1:0]);

    ctrl_launch u_launch (
        .clk         (fclk),
        .rst_n       (frst_n),
        .wr_en       (wr_en),
        .wr_field    (wr_field),
        .ack_sync    (ack_sync),
        .req_tgl     (req_tgl),
        .launch_data (launch_data),
        .shadow      (shadow),
        .busy        (busy),
        .pend_valid  (pend_valid)
    );

    toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (sclk),
        .rst_n (srst_n),
        .d     (req_tgl),
        .q     (req_sync)
    );

    ctrl_capture u_capture (
        .clk         (sclk),
        .rst_n       (srst_n),
        .req_sync    (req_sync),
        .launch_data (launch_data),
        .ack_tgl     (ack_tgl),
        .s_field     (s_field)
    );

    toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (fclk),
        .rst_n (frst_n),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    assign rd_data  = {{PAD_W{1'b0}}, shadow};
    assign s_tx_off = s_field.tx_off;
    assign s_rx_off = s_field.rx_off;
    assign s_alt    = s_field.alt_mode;

    // R2
    readback_follows_write_chk: assert property (@(posedge fclk) disable iff (!frst_n)
        wr_en |=> (rd_data[FIELD_W-1:0] == $past(wr_data[FIELD_W-1:0])));
endmodule

// File: tb/test_ctrl_xfer_cdc.sv
`timescale 1ns/1ps
module test_ctrl_xfer_cdc;
    localparam real CLK_PERIOD  = 4.0;
    localparam real SCLK_PERIOD = 38.0;
    localparam int  REG_W       = 8;

    logic             fclk = 0, sclk = 0;
    logic             frst_n = 0, srst_n = 0;
    logic             wr_en = 0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             busy, pend_valid, s_tx_off, s_rx_off, s_alt;

    int n_checks = 0;
    int n_fail   = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    realtime    t_q[$];

    always #(CLK_PERIOD/2)  fclk = ~fclk;
    always #(SCLK_PERIOD/2) sclk = ~sclk;

    ctrl_xfer_cdc #(.REG_W(REG_W), .SYNC_STAGES(2)) i_ctrl_xfer_cdc (
        .fclk(fclk), .frst_n(frst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .pend_valid(pend_valid),
        .sclk(sclk), .srst_n(srst_n),
        .s_tx_off(s_tx_off), .s_rx_off(s_rx_off), .s_alt(s_alt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] s_now();
        return {s_alt, s_rx_off, s_tx_off};
    endfunction

    // driver: one write; optionally pushes the expected slow-domain value
    task automatic write_reg(input logic [REG_W-1:0] v, input bit push,
                             input string tag, input bit timed);
        bit was_busy;
        @(negedge fclk);
        was_busy = busy;
        wr_en = 1; wr_data = v;
        if (push) begin
            exp_q.push_back(v[2:0]);
            tag_q.push_back(tag);
            t_q.push_back(timed ? $realtime + CLK_PERIOD/2 : 0.0);
        end
        @(negedge fclk);
        wr_en = 0;
        check(rd_data == {5'b0, v[2:0]}, "R2 readback", rd_data, {5'b0, v[2:0]});
        if (!was_busy) check(busy == 1'b1, "R3 busy after launch", busy, 1);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while ((busy || pend_valid) && n < 4000) begin
            @(negedge fclk);
            n++;
        end
        check(!busy && !pend_valid, tag, {busy, pend_valid}, 0);
    endtask

    // monitor: compares each slow-domain change with the scoreboard
    initial begin
        logic [2:0] prev;
        prev = 3'b000;
        forever begin
            @(negedge sclk);
            if (srst_n && s_now() != prev) begin
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected slow update", s_now(), prev);
                end else begin
                    logic [2:0] e;
                    string      tg;
                    realtime    t0;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    t0 = t_q.pop_front();
                    check(s_now() == e, tg, s_now(), e);
                    if (t0 != 0.0)
                        check(($realtime - t0) <= 5.0*SCLK_PERIOD, "R4 latency",
                              int'($realtime - t0), int'(5.0*SCLK_PERIOD));
                end
                prev = s_now();
            end
        end
    end

    initial begin
        #(150000.0*CLK_PERIOD);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        realtime tw;
        repeat (3) @(negedge sclk);
        frst_n = 1; srst_n = 1;
        @(negedge fclk);
        // R1
        check(rd_data == 0, "R1 rd_data", rd_data, 0);
        check(busy == 0, "R1 busy", busy, 0);
        check(pend_valid == 0, "R1 pend_valid", pend_valid, 0);
        check(s_now() == 0, "R1 slow field", s_now(), 0);

        // single transfer; R8 busy fall bound
        tw = $realtime;
        write_reg(8'h05, 1, "R4 single", 1);
        while (busy) @(negedge fclk);
        check(($realtime - tw) <= 5.0*SCLK_PERIOD + 6.0*CLK_PERIOD, "R8 busy fall",
              int'($realtime - tw), int'(5.0*SCLK_PERIOD + 6.0*CLK_PERIOD));
        wait_idle("R8 idle");

        // reserved bits ignored, R2
        write_reg(8'hFA, 1, "R2 field only", 1);
        wait_idle("R8 idle");

        // burst: first value delivered, then only newest
        write_reg(8'h03, 1, "R5 first of burst", 1);
        write_reg(8'h06, 0, "", 0);
        check(pend_valid == 1, "R6 pend set", pend_valid, 1);
        write_reg(8'h01, 0, "", 0);
        write_reg(8'h04, 1, "R7 newest held", 0);
        check(pend_valid == 1 && busy == 1, "R6 still pending", {busy, pend_valid}, 3);
        while (pend_valid) @(negedge fclk);
        check(busy == 1, "R7 busy across relaunch", busy, 1);
        wait_idle("R7 idle");

        // rewrite same value: no slow change, R8
        write_reg(8'h04, 0, "", 0);
        wait_idle("R8 same value");
        repeat (6) @(negedge sclk);
        check(s_now() == 3'h4, "R8 unchanged output", s_now(), 4);

        // sweep a second write across the whole transfer window
        for (int k = 0; k < 70; k++) begin
            logic [2:0] a, b;
            a = 3'((k % 7) + 1) ^ 3'h0;
            if (a == s_now()) a = ~a;
            b = ~a;
            write_reg({5'b0, a}, 1, "R5 sweep first", 1);
            repeat (k) @(negedge fclk);
            write_reg({5'b0, b}, 1, "R7 sweep second", 0);
            wait_idle("R7 sweep idle");
            repeat (6) @(negedge sclk);
        end

        repeat (8) @(negedge sclk);
        check(exp_q.size() == 0, "R7 nothing lost", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule